// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block guards a system against software that stops making progress. A free-running prescaler divides the system clock by a power of two, and its ticks advance a timeout counter. If the timeout counter runs all the way out, the block raises a system reset request for one clock cycle.

Software controls the block through one bit of a control register that sits on a small register port. The port has an address, write data, a write strobe and a combinational read-data path. Writing a one to that bit arms the watchdog. Each later write of a one to the same bit restarts the whole count. Once the watchdog is armed, nothing software writes can disarm it. Only a hardware reset returns it to the disarmed state, and that includes the reset its own request causes.

Both counter widths are parameters. The defaults give a prescaler of 2^13 and a timeout counter of 2^8, for a total window of 2^21 clock cycles. A bench can shrink both widths to keep the window short.

Top module: `wdt_lockable`

## Requirements
- R1: After `rst_n` is asserted (low), the watchdog is disarmed, `rst_req` is 0, and reading address 0x0C returns 0.
- R2: A write to address 0x0C with data bit 0 set arms the watchdog. From then on, a read of 0x0C returns 1 in bit 0 and 0 in every other bit.
- R3: A write to 0x0C with data bit 0 clear has no effect. It does not arm a disarmed watchdog, does not disarm an armed one, and does not restart the count.
- R4: Once armed, the watchdog stays armed through any sequence of writes and through its own timeouts, until `rst_n` is asserted.
- R5: Let e be the clock edge that samples a servicing write (a write of 1 to bit 0 of 0x0C). If no further servicing write follows, `rst_req` goes high on edge e + 2^(PRESCALE_W+TIMEOUT_W).
- R6: `rst_req` is high for exactly one clock cycle. The timeout restarts from zero on the same edge, so without servicing the next request comes 2^(PRESCALE_W+TIMEOUT_W) edges later.
- R7: A servicing write restarts the count. When it is sampled on the very edge where a request would otherwise be raised, no request is raised.
- R8: Writes to any address other than 0x0C neither arm nor service the watchdog.
- R9: Reads of any address other than 0x0C return 0.
- R10: While the watchdog is disarmed, `rst_req` never goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | ADDR_W | Register byte address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| rst_req | output | 1 | One-cycle system reset request on timeout |

## Verification
The assertions check on every cycle the properties that hold locally:
- the armed state never falls back;
- a disarmed block never starts arming without a servicing write;
- a request lasts one cycle and only follows an armed cycle;
- a servicing write always leaves both counters at zero with no request behind it.

The exact timeout distance is shown only by the bench's scenarios, through a scoreboard of expected request cycles. These scenarios cover:
- the one-cycle request and restart that come back without servicing;
- writes of zero and writes to other addresses, which leave the deadline unchanged;
- a servicing write landing on the exact expiry edge;
- the return to the disarmed state after a hardware reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Servicing strobe: a write to the control register with the control bit set.
  function automatic logic is_service(input logic hit, input logic we, input logic bitv);
    return hit & we & bitv;
  endfunction

  // Count is at its last value: every bit of the counter is one.
  function automatic logic at_terminal(input logic [31:0] cnt, input int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (cnt & mask) == mask;
  endfunction

  // Next value of a counter that clears on a restart and otherwise advances when enabled.
  function automatic logic [31:0] next_count(input logic [31:0] cnt, input logic restart,
                                             input logic advance);
    if (restart) return 32'd0;
    if (advance) return cnt + 32'd1;
    return cnt;
  endfunction

endpackage

// File: rtl/wdt_regif.sv
module wdt_regif #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 8'h0C,
  parameter int unsigned CTRL_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ctrl_wbit,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output logic              svc_kick,
  output logic              armed
);
  import wdt_pkg::*;

  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_ADDR);

  logic ctrl_hit;
  logic armed_q;

  assign ctrl_hit = (addr == CtrlAddr);
  assign svc_kick = is_service(ctrl_hit, we, ctrl_wbit);
  assign armed    = armed_q;

  // Arm on the first servicing write; only the hardware reset clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (svc_kick) armed_q <= 1'b1;
  end

  // Read data: the armed state in the control-bit position, zero elsewhere.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rd
    if (i == CTRL_BIT) begin : g_ctrl
      assign rdata[i] = ctrl_hit & armed_q;
    end else begin : g_zero
      assign rdata[i] = 1'b0;
    end
  end

  // R4: software can never disarm the block.
  p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

  // R3, R8: without a servicing write a disarmed block stays disarmed.
  p_arm_needs_kick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !svc_kick) |=> !armed_q);

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned WIDTH = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  import wdt_pkg::*;

  logic [WIDTH-1:0] cnt_q;
  logic [31:0]      cnt_ext;

  assign cnt_ext = 32'(cnt_q);
  assign tick    = at_terminal(cnt_ext, WIDTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= WIDTH'(next_count(cnt_ext, restart, 1'b1));
  end

  // R7: a restart leaves a full prescaler period before the next tick.
  p_restart_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout #(
  parameter int unsigned WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic tick,
  input  logic svc_kick,
  output logic expire
);
  import wdt_pkg::*;

  logic [WIDTH-1:0] cnt_q;
  logic [31:0]      cnt_ext;
  logic             last_step;

  assign cnt_ext   = 32'(cnt_q);
  assign last_step = armed & tick & at_terminal(cnt_ext, WIDTH);
  // A servicing write on the final edge wins over the expiry.
  assign expire    = last_step & ~svc_kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= WIDTH'(next_count(cnt_ext, svc_kick | expire, armed & tick));
  end

  // R7: servicing always zeroes the timeout count.
  p_kick_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_kick |=> (cnt_q == '0));

  // R6: an expiry restarts the count and cannot repeat at once.
  p_expire_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0) && !expire);

endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CTRL_ADDR  = 8'h0C,
  parameter int unsigned CTRL_BIT   = 0,
  parameter int unsigned PRESCALE_W = 13,
  parameter int unsigned TIMEOUT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);

  logic svc_kick;
  logic armed;
  logic tick;
  logic expire;
  logic req_q;

  wdt_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .CTRL_BIT(CTRL_BIT)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .ctrl_wbit(bus_wdata[CTRL_BIT]),
    .we(bus_we), .rdata(bus_rdata), .svc_kick(svc_kick), .armed(armed)
  );

  wdt_prescaler #(.WIDTH(PRESCALE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(svc_kick | expire), .tick(tick)
  );

  wdt_timeout #(.WIDTH(TIMEOUT_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .armed(armed), .tick(tick),
    .svc_kick(svc_kick), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= expire;
  end

  assign rst_req = req_q;

  // R6: the request is a single-cycle pulse.
  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R10: a request only follows a cycle in which the block was armed.
  p_req_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(armed));

  // R7: no request right after a servicing write.
  p_no_req_after_kick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_kick |=> !rst_req);

endmodule

// File: tb/wdt_lockable_bench.sv
`timescale 1ns/1ps
module wdt_lockable_bench;

  localparam int P = 3;
  localparam int T = 4;
  localparam int WINDOW = 128;  // 2^(P+T)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  bit model_en = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  wdt_lockable #(.PRESCALE_W(P), .TIMEOUT_W(T)) u_wdt_lockable (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: samples 1 ns after each edge and compares against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0 && exp_q[0] == cyc) begin
      checks++;
      if (!rst_req) begin
        errors++;
        $display("FAIL R5 R6: no request at cycle %0d: actual 0 expected 1", cyc);
      end else begin
        pulses++;
        if (model_en) exp_q.push_back(cyc + WINDOW);
      end
      void'(exp_q.pop_front());
    end else if (rst_req) begin
      checks++;
      errors++;
      pulses++;
      $display("FAIL R7 R10: unexpected request at cycle %0d: actual 1 expected 0", cyc);
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Driver: one write, scoreboard updated for the edge that samples it.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    int e;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    e = cyc + 1;
    if (a == 8'h0C && d[0]) begin
      model_en = 1'b1;
      while (exp_q.size() > 0 && exp_q[exp_q.size()-1] >= e) void'(exp_q.pop_back());
      exp_q.push_back(e + WINDOW);
    end
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_en = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: bench hung: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int p0;
    do_reset();
    // R1 reset state
    check("R1 rst_req after reset", int'(rst_req), 0);
    rd(8'h0C, v); check("R1 control read after reset", v, 0);

    // R3 zero write while disarmed; R10 no request while disarmed
    wr(8'h0C, 8'h00);
    idle(300);
    rd(8'h0C, v); check("R3 zero write does not arm", v, 0);
    check("R10 no request while disarmed", pulses, 0);
    // R8 write to other address does not arm
    wr(8'h0D, 8'hFF);
    idle(300);
    rd(8'h0C, v); check("R8 foreign write does not arm", v, 0);
    // R9 other addresses read zero
    rd(8'h0D, v); check("R9 read of 0x0D", v, 0);

    // R2 arming
    wr(8'h0C, 8'h01);
    rd(8'h0C, v); check("R2 armed read", v, 1);
    rd(8'h05, v); check("R9 read of 0x05 while armed", v, 0);

    // R3 and R8: zero write and foreign write keep the deadline (R5 by scoreboard)
    idle(40);
    wr(8'h0C, 8'hFE);
    wr(8'h0D, 8'h01);
    while (pulses < 1) @(negedge clk);
    rd(8'h0C, v); check("R4 still armed after timeout", v, 1);
    // R6 restart without service gives a second pulse one window later
    while (pulses < 2) @(negedge clk);
    check("R6 second pulse seen", pulses, 2);

    // R7 periodic servicing keeps requests away
    p0 = pulses;
    for (int k = 0; k < 5; k++) begin
      idle(100);
      wr(8'h0C, 8'h81);
    end
    check("R7 no request while serviced", pulses, p0);
    // R7 servicing on the exact expiry edge suppresses it
    while (exp_q[0] != cyc + 2) @(negedge clk);
    wr(8'h0C, 8'h01);
    idle(20);
    check("R7 service on expiry edge suppresses request", pulses, p0);
    // R4 zero writes cannot disarm
    for (int k = 0; k < 4; k++) wr(8'h0C, 8'h00);
    rd(8'h0C, v); check("R4 zero writes leave it armed", v, 1);
    while (pulses < p0 + 1) @(negedge clk);

    // R1 hardware reset disarms; R10 stays quiet afterwards
    do_reset();
    rd(8'h0C, v); check("R1 reset disarms", v, 0);
    p0 = pulses;
    idle(400);
    check("R10 no request after reset", pulses, p0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule